// File: doc/BRIEF.md
# Exception Priority Resolver and Escalator

This block keeps the per-exception bookkeeping of a small processor interrupt controller and turns it into one decision: whether the pending exception may preempt the code now running. Each exception slot has an enable, a pending flag, an active flag and a priority. The block selects the pending winner. It folds the active set into a group-masked active priority, and it combines that with three mask inputs to produce the current execution priority.

Requests arrive as single-cycle strobes that carry an exception number: set-pending, acknowledge (which takes the current winner), complete, enable writes and priority writes. A set-pending request for a synchronous fault that cannot be taken at once is redirected to the hard-fault slot, and a sticky status bit records the redirection. If the hard fault could not be taken either, a sticky lockup flag is raised and nothing is pended. Slot numbers follow the usual layout: 1 reset, 2 NMI, 3 hard fault, 4 to 13 fault and system slots (11 supervisor call, 12 debug), 14 deferred service call, 15 system tick, and 16 upward external interrupts. Priorities are carried as 10-bit signed values.

Top module: `exc_prio_resolver`

## Requirements
- R1: When nothing is enabled and pending, `pend_num` is 0 and `pend_prio` is 256. When nothing is active, `act_prio` is 256. With no mask input set, `exec_prio` is also 256.
- R2: The winner is the enabled, pending slot with the numerically smallest priority. On a tie the lowest slot number wins. A disabled pending slot never wins.
- R3: `act_prio` is the smallest priority among active slots. When that value is non-negative, it is ANDed with all-ones shifted left by `grp_split`+1. Negative fixed priorities pass through unmasked.
- R4: The running level is -1 when `fault_mask` is set. Otherwise it is 0 when `prim_mask` is set. Otherwise it is `base_prio` group-masked when `base_prio` is nonzero, and 256 in any other case. `exec_prio` is the smaller of the running level and `act_prio`.
- R5: `preempt_req` is 1 exactly when `pend_prio` < `act_prio`. The three mask inputs have no effect on it.
- R6: After reset, slots 1, 2 and 3 have fixed priorities -3, -2 and -1, and priority or enable writes to these slots are ignored. Slots 2, 3, 11, 12, 14 and 15 start enabled. All other slots start disabled with priority 0. No slot starts pending or active.
- R7: A set-pending request for slot 3 to 13 escalates when the slot's priority is >= `exec_prio` or the slot is disabled. In that case slot 3 becomes pending instead and `esc_forced` is set, and it stays set until reset.
- R8: If an escalating request finds `exec_prio` <= -1, nothing is pended and `lockup` is set, and it stays set until reset.
- R9: An acknowledge clears the winner's pending flag and sets its active flag. An acknowledge with no winner changes nothing.
- R10: Complete clears the slot's active flag. Complete on a slot that is not active raises `illegal_ret` for exactly the one cycle after the strobe.
- R11: When an operation sets a pending or active flag and another clears the same flag in the same cycle, the set wins. This applies to set-pending against acknowledge, and to acknowledge against complete.
- R12: Set-pending to slot 0, to slot 1, or to a number >= `NUM_EXC` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pend_vld | input | 1 | Set-pending strobe |
| set_pend_num | input | IDX_W | Slot for set-pending |
| ack_vld | input | 1 | Acknowledge the current winner |
| cmpl_vld | input | 1 | Complete strobe |
| cmpl_num | input | IDX_W | Slot being completed |
| en_wr_vld | input | 1 | Enable write strobe |
| en_wr_num | input | IDX_W | Slot for enable write |
| en_wr_val | input | 1 | New enable value |
| prio_wr_vld | input | 1 | Priority write strobe |
| prio_wr_num | input | IDX_W | Slot for priority write |
| prio_wr_val | input | PRIO_W | New priority |
| grp_split | input | 3 | Group/subpriority split point |
| fault_mask | input | 1 | Raise running level to -1 |
| prim_mask | input | 1 | Raise running level to 0 |
| base_prio | input | PRIO_W | Base priority threshold, 0 means off |
| pend_num | output | IDX_W | Winning pending slot, 0 if none |
| pend_prio | output | 10 | Winner priority (signed) |
| act_prio | output | 10 | Group-masked active priority (signed) |
| exec_prio | output | 10 | Current execution priority (signed) |
| preempt_req | output | 1 | Winner beats the active priority |
| lockup | output | 1 | Sticky lockup flag |
| esc_forced | output | 1 | Sticky escalation flag |
| illegal_ret | output | 1 | Complete hit an inactive slot |

## Verification
Two updates can land in the same cycle: acknowledge, which clears the winner's pending flag and sets its active flag, and a set-pending or complete on that same slot. The bench raises acknowledge together with a set-pending of the current winner and expects the slot to end both active and pending again. It then raises acknowledge together with a complete of that slot and expects the slot to remain active and `illegal_ret` to stay low. Each result is judged through `pend_num`, `act_prio` and `illegal_ret` one edge later.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

  localparam int SPW = 10;
  typedef logic signed [SPW-1:0] sprio_t;

  localparam sprio_t PRIO_IDLE = 10'sd256;
  localparam sprio_t PRIO_RST  = -10'sd3;
  localparam sprio_t PRIO_NMI  = -10'sd2;
  localparam sprio_t PRIO_HARD = -10'sd1;

  localparam int X_RESET   = 1;
  localparam int X_NMI     = 2;
  localparam int X_HARD    = 3;
  localparam int X_SVCALL  = 11;
  localparam int X_DBG     = 12;
  localparam int X_DEFER   = 14;
  localparam int X_TICK    = 15;
  localparam int X_EXT0    = 16;

  // fixed priority of the three non-programmable slots
  function automatic sprio_t fixed_prio(input int idx);
    case (idx)
      X_RESET: return PRIO_RST;
      X_NMI:   return PRIO_NMI;
      default: return PRIO_HARD;
    endcase
  endfunction

  // enable value taken out of reset by programmable slots
  function automatic logic boot_enable(input int idx);
    return (idx == X_SVCALL) || (idx == X_DBG) || (idx == X_DEFER) || (idx == X_TICK);
  endfunction

  // strip subpriority bits; fixed negative priorities are left intact
  function automatic sprio_t grp_mask(input sprio_t p, input logic [2:0] split);
    logic [SPW-1:0] m;
    m = {SPW{1'b1}} << (32'(split) + 1);
    if (p < 0) return p;
    return p & sprio_t'(m);
  endfunction

endpackage

// File: rtl/exc_slot_bank.sv
module exc_slot_bank
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXC = 24,
  parameter int PRIO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXC-1:0] pend_set,
  input  logic [NUM_EXC-1:0] pend_clr,
  input  logic [NUM_EXC-1:0] act_set,
  input  logic [NUM_EXC-1:0] act_clr,
  input  logic [NUM_EXC-1:0] en_we,
  input  logic               en_wval,
  input  logic [NUM_EXC-1:0] prio_we,
  input  logic [PRIO_W-1:0]  prio_wval,
  output logic [NUM_EXC-1:0] en_q,
  output logic [NUM_EXC-1:0] pend_q,
  output logic [NUM_EXC-1:0] act_q,
  output sprio_t             prio_q [NUM_EXC]
);

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_slot
    if (i == 0) begin : g_null
      assign en_q[i]   = 1'b0;
      assign pend_q[i] = 1'b0;
      assign act_q[i]  = 1'b0;
      assign prio_q[i] = PRIO_IDLE;
      logic unused_null;
      assign unused_null = ^{pend_set[i], pend_clr[i], act_set[i], act_clr[i],
                             en_we[i], prio_we[i]};
    end else begin : g_live
      logic pend_r, pend_d, act_r, act_d;

      always_comb begin
        pend_d = (pend_r & ~pend_clr[i]) | pend_set[i];
        act_d  = (act_r  & ~act_clr[i])  | act_set[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_r <= 1'b0;
          act_r  <= 1'b0;
        end else begin
          pend_r <= pend_d;
          act_r  <= act_d;
        end
      end

      assign pend_q[i] = pend_r;
      assign act_q[i]  = act_r;

      if (i <= X_HARD) begin : g_fixed
        assign en_q[i]   = (i >= X_NMI);
        assign prio_q[i] = fixed_prio(i);
        logic unused_fixed;
        assign unused_fixed = ^{en_we[i], prio_we[i]};
      end else begin : g_prog
        logic              en_r, en_d;
        logic [PRIO_W-1:0] pr_r, pr_d;

        always_comb begin
          en_d = en_we[i]   ? en_wval   : en_r;
          pr_d = prio_we[i] ? prio_wval : pr_r;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            en_r <= boot_enable(i);
            pr_r <= '0;
          end else begin
            en_r <= en_d;
            pr_r <= pr_d;
          end
        end

        assign en_q[i]   = en_r;
        assign prio_q[i] = sprio_t'(pr_r);
      end
    end
  end

endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXC = 24,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic [NUM_EXC-1:0] en_q,
  input  logic [NUM_EXC-1:0] pend_q,
  input  logic [NUM_EXC-1:0] act_q,
  input  sprio_t             prio_q [NUM_EXC],
  input  logic [2:0]         grp_split,
  output logic [IDX_W-1:0]   win_num,
  output sprio_t             win_prio,
  output sprio_t             act_prio
);

  sprio_t amin;

  // upward scan with strict compare: lowest index keeps a tie
  always_comb begin
    win_num  = '0;
    win_prio = PRIO_IDLE;
    amin     = PRIO_IDLE;
    for (int i = 1; i < NUM_EXC; i++) begin
      if (en_q[i] && pend_q[i] && (prio_q[i] < win_prio)) begin
        win_prio = prio_q[i];
        win_num  = IDX_W'(i);
      end
      if (act_q[i] && (prio_q[i] < amin)) begin
        amin = prio_q[i];
      end
    end
    act_prio = grp_mask(amin, grp_split);
  end

endmodule

// File: rtl/exc_exec_prio.sv
module exc_exec_prio
  import exc_prio_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              fault_mask,
  input  logic              prim_mask,
  input  logic [PRIO_W-1:0] base_prio,
  input  logic [2:0]        grp_split,
  input  sprio_t            act_prio,
  input  sprio_t            win_prio,
  output sprio_t            exec_prio,
  output logic              preempt_req
);

  sprio_t running;

  always_comb begin
    if (fault_mask)           running = -10'sd1;
    else if (prim_mask)       running = '0;
    else if (base_prio != '0) running = grp_mask(sprio_t'(base_prio), grp_split);
    else                      running = PRIO_IDLE;

    exec_prio   = (running < act_prio) ? running : act_prio;
    preempt_req = (win_prio < act_prio);
  end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXC = 24,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic               set_vld,
  input  logic [IDX_W-1:0]   set_num,
  input  logic [NUM_EXC-1:0] en_q,
  input  sprio_t             prio_q [NUM_EXC],
  input  sprio_t             exec_prio,
  output logic [NUM_EXC-1:0] pend_set,
  output logic               forced_set,
  output logic               lockup_set
);

  logic in_range, sync_fault, must_esc;

  always_comb begin
    pend_set   = '0;
    forced_set = 1'b0;
    lockup_set = 1'b0;
    in_range   = (32'(set_num) > X_RESET) && (32'(set_num) < NUM_EXC);
    sync_fault = (32'(set_num) >= X_HARD) && (32'(set_num) < X_DEFER);
    must_esc   = 1'b0;
    if (set_vld && in_range) begin
      if (sync_fault) begin
        must_esc = (prio_q[set_num] >= exec_prio) || !en_q[set_num];
      end
      if (!must_esc) begin
        pend_set[set_num] = 1'b1;
      end else if (PRIO_HARD >= exec_prio) begin
        lockup_set = 1'b1;
      end else begin
        pend_set[X_HARD] = 1'b1;
        forced_set       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXC = 24,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_pend_vld,
  input  logic [IDX_W-1:0]    set_pend_num,
  input  logic                ack_vld,
  input  logic                cmpl_vld,
  input  logic [IDX_W-1:0]    cmpl_num,
  input  logic                en_wr_vld,
  input  logic [IDX_W-1:0]    en_wr_num,
  input  logic                en_wr_val,
  input  logic                prio_wr_vld,
  input  logic [IDX_W-1:0]    prio_wr_num,
  input  logic [PRIO_W-1:0]   prio_wr_val,
  input  logic [2:0]          grp_split,
  input  logic                fault_mask,
  input  logic                prim_mask,
  input  logic [PRIO_W-1:0]   base_prio,
  output logic [IDX_W-1:0]    pend_num,
  output logic signed [9:0]   pend_prio,
  output logic signed [9:0]   act_prio,
  output logic signed [9:0]   exec_prio,
  output logic                preempt_req,
  output logic                lockup,
  output logic                esc_forced,
  output logic                illegal_ret
);

  localparam logic [NUM_EXC-1:0] ONE = NUM_EXC'(1);

  logic [NUM_EXC-1:0] en_q, pend_q, act_q;
  sprio_t             prio_q [NUM_EXC];
  logic [NUM_EXC-1:0] pend_set, pend_clr, act_set, act_clr, en_we, prio_we;
  logic               forced_set, lockup_set;
  logic               ack_take, cmpl_hit;
  logic               forced_q, forced_d, lock_q, lock_d, illeg_q, illeg_d;
  sprio_t             win_prio_w, act_prio_w, exec_prio_w;

  exc_slot_bank #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .act_set  (act_set),
    .act_clr  (act_clr),
    .en_we    (en_we),
    .en_wval  (en_wr_val),
    .prio_we  (prio_we),
    .prio_wval(prio_wr_val),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .prio_q   (prio_q)
  );

  exc_pick #(.NUM_EXC(NUM_EXC)) u_pick (
    .en_q     (en_q),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .prio_q   (prio_q),
    .grp_split(grp_split),
    .win_num  (pend_num),
    .win_prio (win_prio_w),
    .act_prio (act_prio_w)
  );

  exc_exec_prio #(.PRIO_W(PRIO_W)) u_exec (
    .fault_mask (fault_mask),
    .prim_mask  (prim_mask),
    .base_prio  (base_prio),
    .grp_split  (grp_split),
    .act_prio   (act_prio_w),
    .win_prio   (win_prio_w),
    .exec_prio  (exec_prio_w),
    .preempt_req(preempt_req)
  );

  exc_escalate #(.NUM_EXC(NUM_EXC)) u_esc (
    .set_vld   (set_pend_vld),
    .set_num   (set_pend_num),
    .en_q      (en_q),
    .prio_q    (prio_q),
    .exec_prio (exec_prio_w),
    .pend_set  (pend_set),
    .forced_set(forced_set),
    .lockup_set(lockup_set)
  );

  // acknowledge, complete and configuration-write decode
  always_comb begin
    ack_take = ack_vld && (pend_num != '0);
    pend_clr = ack_take ? (ONE << pend_num) : '0;
    act_set  = pend_clr;

    cmpl_hit = cmpl_vld && (32'(cmpl_num) < NUM_EXC) && act_q[cmpl_num];
    act_clr  = cmpl_hit ? (ONE << cmpl_num) : '0;
    illeg_d  = cmpl_vld && !cmpl_hit;

    en_we   = (en_wr_vld && (32'(en_wr_num) < NUM_EXC)) ? (ONE << en_wr_num) : '0;
    prio_we = (prio_wr_vld && (32'(prio_wr_num) < NUM_EXC)) ? (ONE << prio_wr_num) : '0;

    forced_d = forced_q | forced_set;
    lock_d   = lock_q | lockup_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forced_q <= 1'b0;
      lock_q   <= 1'b0;
      illeg_q  <= 1'b0;
    end else begin
      forced_q <= forced_d;
      lock_q   <= lock_d;
      illeg_q  <= illeg_d;
    end
  end

  assign pend_prio   = win_prio_w;
  assign act_prio    = act_prio_w;
  assign exec_prio   = exec_prio_w;
  assign lockup      = lock_q;
  assign esc_forced  = forced_q;
  assign illegal_ret = illeg_q;

endmodule

// File: rtl/exc_prio_resolver_chk.sv
module exc_prio_resolver_chk
  import exc_prio_pkg::*;
#(
  parameter int NUM_EXC = 24,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_vld,
  input logic               cmpl_vld,
  input logic [IDX_W-1:0]   cmpl_num,
  input logic [IDX_W-1:0]   pend_num,
  input logic signed [9:0]  pend_prio,
  input logic signed [9:0]  act_prio,
  input logic signed [9:0]  exec_prio,
  input logic               preempt_req,
  input logic               lockup,
  input logic               illegal_ret,
  input logic [NUM_EXC-1:0] en_q,
  input logic [NUM_EXC-1:0] pend_q,
  input logic [NUM_EXC-1:0] act_q
);

  a_r1_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_num == '0) |-> (pend_prio == 10'sd256));

  a_r2_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_num != '0) |-> (en_q[pend_num] && pend_q[pend_num]));

  a_r4_exec_bound: assert property (@(posedge clk) disable iff (!rst_n)
    exec_prio <= act_prio);

  a_r5_preempt_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> (pend_num != '0));

  a_r8_lockup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> lockup);

  a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && (pend_num != '0)) |=> act_q[$past(pend_num)]);

  a_r10_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld && !act_q[cmpl_num]) |=> illegal_ret);

endmodule

bind exc_prio_resolver exc_prio_resolver_chk #(.NUM_EXC(NUM_EXC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_vld    (ack_vld),
  .cmpl_vld   (cmpl_vld),
  .cmpl_num   (cmpl_num),
  .pend_num   (pend_num),
  .pend_prio  (pend_prio),
  .act_prio   (act_prio),
  .exec_prio  (exec_prio),
  .preempt_req(preempt_req),
  .lockup     (lockup),
  .illegal_ret(illegal_ret),
  .en_q       (en_q),
  .pend_q     (pend_q),
  .act_q      (act_q)
);

// File: tb/exc_prio_resolver_tb.sv
module exc_prio_resolver_tb;

  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic set_pend_vld, ack_vld, cmpl_vld, en_wr_vld, en_wr_val, prio_wr_vld;
  logic fault_mask, prim_mask;
  logic [IDX_W-1:0] set_pend_num, cmpl_num, en_wr_num, prio_wr_num, pend_num;
  logic [7:0] prio_wr_val, base_prio;
  logic [2:0] grp_split;
  logic signed [9:0] pend_prio, act_prio, exec_prio;
  logic preempt_req, lockup, esc_forced, illegal_ret;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  exc_prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n),
    .set_pend_vld(set_pend_vld), .set_pend_num(set_pend_num),
    .ack_vld(ack_vld), .cmpl_vld(cmpl_vld), .cmpl_num(cmpl_num),
    .en_wr_vld(en_wr_vld), .en_wr_num(en_wr_num), .en_wr_val(en_wr_val),
    .prio_wr_vld(prio_wr_vld), .prio_wr_num(prio_wr_num), .prio_wr_val(prio_wr_val),
    .grp_split(grp_split), .fault_mask(fault_mask), .prim_mask(prim_mask),
    .base_prio(base_prio), .pend_num(pend_num), .pend_prio(pend_prio),
    .act_prio(act_prio), .exec_prio(exec_prio), .preempt_req(preempt_req),
    .lockup(lockup), .esc_forced(esc_forced), .illegal_ret(illegal_ret)
  );

  // mask-input table: {fault, primary, base, split, expected exec priority}
  typedef struct packed {
    logic              fm;
    logic              pm;
    logic [7:0]        base;
    logic [2:0]        split;
    logic signed [9:0] exp;
  } mvec_t;

  localparam mvec_t MVEC [8] = '{
    '{1'b0, 1'b0, 8'h00, 3'd0, 10'sd256},
    '{1'b1, 1'b0, 8'h40, 3'd0, -10'sd1},
    '{1'b0, 1'b1, 8'h40, 3'd0, 10'sd0},
    '{1'b0, 1'b0, 8'h47, 3'd0, 10'sd70},
    '{1'b0, 1'b0, 8'h47, 3'd2, 10'sd64},
    '{1'b0, 1'b0, 8'hFF, 3'd7, 10'sd0},
    '{1'b0, 1'b0, 8'h80, 3'd3, 10'sd128},
    '{1'b1, 1'b1, 8'h20, 3'd1, -10'sd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_pend_vld = 0; set_pend_num = '0; ack_vld = 0; cmpl_vld = 0; cmpl_num = '0;
    en_wr_vld = 0; en_wr_num = '0; en_wr_val = 0; prio_wr_vld = 0; prio_wr_num = '0;
    prio_wr_val = '0; grp_split = '0; fault_mask = 0; prim_mask = 0; base_prio = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_pend(input int n);
    set_pend_vld = 1; set_pend_num = IDX_W'(n);
    @(negedge clk);
    set_pend_vld = 0;
  endtask

  task automatic ack();
    ack_vld = 1;
    @(negedge clk);
    ack_vld = 0;
  endtask

  task automatic complete(input int n);
    cmpl_vld = 1; cmpl_num = IDX_W'(n);
    @(negedge clk);
    cmpl_vld = 0;
  endtask

  task automatic wr_en(input int n, input logic v);
    en_wr_vld = 1; en_wr_num = IDX_W'(n); en_wr_val = v;
    @(negedge clk);
    en_wr_vld = 0;
  endtask

  task automatic wr_prio(input int n, input int p);
    prio_wr_vld = 1; prio_wr_num = IDX_W'(n); prio_wr_val = 8'(p);
    @(negedge clk);
    prio_wr_vld = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 / R6 reset state
    chk("R1 idle pend_num", int'(pend_num), 0);
    chk("R1 idle pend_prio", int'(pend_prio), 256);
    chk("R1 idle act_prio", int'(act_prio), 256);
    chk("R1 idle exec_prio", int'(exec_prio), 256);
    chk("R5 reset preempt", int'(preempt_req), 0);
    chk("R8 reset lockup", int'(lockup), 0);
    chk("R7 reset forced", int'(esc_forced), 0);

    // R4 table of mask inputs with nothing active
    for (int k = 0; k < 8; k++) begin
      fault_mask = MVEC[k].fm; prim_mask = MVEC[k].pm;
      base_prio = MVEC[k].base; grp_split = MVEC[k].split;
      #1;
      chk($sformatf("R4 vector %0d", k), int'(exec_prio), int'(MVEC[k].exp));
      @(negedge clk);
    end
    idle_inputs();

    do_reset();
    set_pend(15);
    chk("R6 tick enabled at reset", int'(pend_num), 15);
    chk("R5 preempt on winner", int'(preempt_req), 1);
    set_pend(16);
    chk("R2 disabled slot skipped", int'(pend_num), 15);
    wr_en(16, 1'b1);
    chk("R2 tie lowest index", int'(pend_num), 15);
    wr_prio(16, 8'h08);
    wr_prio(15, 8'h12);
    chk("R2 smaller prio wins", int'(pend_num), 16);
    chk("R2 winner prio", int'(pend_prio), 8);
    fault_mask = 1; #1;
    chk("R5 masks ignored", int'(preempt_req), 1);
    chk("R4 fault mask level", int'(exec_prio), -1);
    @(negedge clk); fault_mask = 0;

    ack();
    chk("R9 ack next winner", int'(pend_num), 15);
    chk("R9 ack active prio", int'(act_prio), 8);
    chk("R5 no preempt", int'(preempt_req), 0);
    wr_prio(16, 8'h18);
    chk("R3 split0 act", int'(act_prio), 24);
    chk("R5 preempt split0", int'(preempt_req), 1);
    grp_split = 3'd3; #1;
    chk("R3 split3 act", int'(act_prio), 16);
    chk("R5 subprio no preempt", int'(preempt_req), 0);
    @(negedge clk); grp_split = 3'd0;

    // R11: acknowledge and set-pending of the winner together
    ack_vld = 1; set_pend_vld = 1; set_pend_num = IDX_W'(15);
    @(negedge clk);
    ack_vld = 0; set_pend_vld = 0;
    chk("R11 set-pend beats ack", int'(pend_num), 15);
    chk("R11 slot also active", int'(act_prio), 18);
    // R11: acknowledge and complete of the same slot together
    ack_vld = 1; cmpl_vld = 1; cmpl_num = IDX_W'(15);
    @(negedge clk);
    ack_vld = 0; cmpl_vld = 0;
    chk("R11 ack beats complete", int'(act_prio), 18);
    chk("R11 pend cleared", int'(pend_num), 0);
    chk("R11 no illegal", int'(illegal_ret), 0);

    complete(15);
    chk("R10 complete clears", int'(act_prio), 24);
    chk("R10 legal complete", int'(illegal_ret), 0);
    complete(16);
    chk("R10 all inactive", int'(act_prio), 256);
    complete(16);
    chk("R10 illegal return", int'(illegal_ret), 1);
    @(negedge clk);
    chk("R10 illegal one cycle", int'(illegal_ret), 0);
    ack();
    chk("R9 empty ack no effect", int'(act_prio), 256);
    set_pend(0);
    set_pend(1);
    set_pend(30);
    chk("R12 bad set-pend ignored", int'(pend_num), 0);

    // escalation and lockup
    set_pend(6);
    chk("R7 disabled fault escalates", int'(pend_num), 3);
    chk("R7 hard prio", int'(pend_prio), -1);
    chk("R7 forced flag", int'(esc_forced), 1);
    wr_prio(3, 8'h00);
    chk("R6 fixed prio write ignored", int'(pend_prio), -1);
    wr_en(3, 1'b0);
    chk("R6 fixed enable write ignored", int'(pend_num), 3);
    ack();
    chk("R3 negative not masked", int'(act_prio), -1);
    set_pend(4);
    chk("R8 lockup raised", int'(lockup), 1);
    chk("R8 nothing pended", int'(pend_num), 0);
    @(negedge clk);
    chk("R8 lockup sticky", int'(lockup), 1);

    do_reset();
    chk("R7 forced cleared by reset", int'(esc_forced), 0);
    wr_en(5, 1'b1);
    wr_prio(5, 8'h40);
    base_prio = 8'h40;
    set_pend(5);
    chk("R7 equal prio escalates", int'(pend_num), 3);
    chk("R7 forced on prio", int'(esc_forced), 1);

    do_reset();
    wr_en(5, 1'b1);
    wr_prio(5, 8'h20);
    base_prio = 8'h40;
    set_pend(5);
    chk("R7 higher prio not escalated", int'(pend_num), 5);
    chk("R7 forced stays low", int'(esc_forced), 0);
    set_pend(2);
    chk("R6 NMI wins", int'(pend_num), 2);
    chk("R6 NMI prio", int'(pend_prio), -2);

    finish_run();
  end

endmodule